// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit

This block is an 8-bit arithmetic logic unit assembled from identical one-bit slices that pass a carry from the least significant slice to the most significant one. The operation is not chosen by an opcode decoder. A small set of per-operand gates and inverters sits around four basic paths instead. Each operand can be forced to zero, and after that it can be complemented. A two-bit select picks AND, OR, XOR or ADD inside every slice, and a final inverter can complement the chosen result. Subtraction, negation, NAND, NOR, XNOR, pass-through and constant generation all come from combinations of these controls.

The result, the carry output and six status flags are combinational. A registered copy of the flags is provided so that a surrounding datapath or a testbench can sample them one clock later. The register has a synchronous active-low reset.

Top module: `alu_bitslice`

## Requirements
- R1: When `keep_a` (or `keep_b`) is 0, that operand is replaced by zero before any other processing, whatever the value on `opa` (or `opb`).
- R2: When `flip_a` (or `flip_b`) is 1, the gated operand is complemented bitwise. The operand that results is called the effective operand.
- R3: `op_sel` chooses the slice path: 2'b00 gives AND, 2'b01 gives OR, 2'b10 gives XOR of the effective operands, and 2'b11 gives ADD. When `flip_res` is 1, the selected value is complemented before it reaches `result`.
- R4: For every `op_sel`, `carry_out` is bit 8 of effective A + effective B + `carry_in`. During ADD, the selected value is the low 8 bits of that sum. With both operands kept, `flip_b`=1 and `carry_in`=1, ADD gives `opa - opb` modulo 256, and `carry_out` is 1 exactly when `opa >= opb`.
- R5: `flags[0]` (carry) equals `carry_out` when `op_sel` is 2'b11 and is 0 for the logic operations.
- R6: `flags[1]` (parity) is 1 when `result` holds an even number of ones.
- R7: `flags[2]` (adjust) is the carry from bit 3 into bit 4 of the ADD chain when `op_sel` is 2'b11 and is 0 otherwise.
- R8: `flags[3]` (zero) is 1 exactly when all bits of `result` are 0.
- R9: `flags[4]` (negative) equals `result[7]`.
- R10: `flags[5]` (overflow) is 1 during ADD when both effective operands have the same bit 7 and the uninverted sum has a different bit 7. It is 0 for the logic operations.
- R11: `flags_q` takes the value of `flags` at each rising clock edge, and a clock edge with `rst_n` low clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| keep_a | input | 1 | 1 passes operand A, 0 forces it to zero |
| keep_b | input | 1 | 1 passes operand B, 0 forces it to zero |
| flip_a | input | 1 | Complement gated operand A |
| flip_b | input | 1 | Complement gated operand B |
| op_sel | input | 2 | Path select: 00 AND, 01 OR, 10 XOR, 11 ADD |
| flip_res | input | 1 | Complement the selected result |
| carry_in | input | 1 | Carry into slice 0 |
| result | output | 8 | Final result |
| carry_out | output | 1 | Carry out of slice 7 |
| flags | output | 6 | {overflow, negative, zero, adjust, parity, carry}, combinational |
| flags_q | output | 6 | Registered copy of `flags` |

## Verification
Two functions meet in the same cycle here: the result inversion and the flag logic. When `flip_res` and ADD are both active, zero, negative and parity must follow the inverted output, while carry, adjust and overflow must still follow the uninverted sum. The sweep over every control combination drives both functions together on boundary operands such as 0x7F, 0x80, 0x0F and 0xFF. An arithmetic model in the bench judges each flag on its own against the rule for that flag.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding and flag bit positions for the bit-slice ALU.
// Assumes: flag vector bit order is fixed and decoded by neighbouring logic.
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_ADD = 2'b11
    } alu_op_e;

    localparam int FLAG_W = 6;
    localparam int FLG_C  = 0;
    localparam int FLG_P  = 1;
    localparam int FLG_A  = 2;
    localparam int FLG_Z  = 3;
    localparam int FLG_N  = 4;
    localparam int FLG_O  = 5;

endpackage

// File: rtl/alu_slice.sv
// Module: one bit of the ALU. Gates and optionally inverts each operand,
// computes the four candidate paths, selects one and optionally inverts it.
// Assumes: carry logic runs for every operation; only the ADD path uses the sum.
module alu_slice (
    input  logic             a_i,
    input  logic             b_i,
    input  logic             keep_a_i,
    input  logic             keep_b_i,
    input  logic             flip_a_i,
    input  logic             flip_b_i,
    input  logic             flip_res_i,
    input  alu_pkg::alu_op_e op_i,
    input  logic             ci_i,
    output logic             a_eff_o,
    output logic             b_eff_o,
    output logic             raw_o,
    output logic             s_o,
    output logic             co_o
);
    import alu_pkg::*;

    logic a_eff;
    logic b_eff;
    logic raw;

    // Operand conditioning: zero gate first, then inversion.
    always_comb begin
        a_eff = (a_i & keep_a_i) ^ flip_a_i;
        b_eff = (b_i & keep_b_i) ^ flip_b_i;
    end

    // Path selection among AND, OR, XOR and full-adder sum.
    always_comb begin
        unique case (op_i)
            OP_AND:  raw = a_eff & b_eff;
            OP_OR:   raw = a_eff | b_eff;
            OP_XOR:  raw = a_eff ^ b_eff;
            default: raw = a_eff ^ b_eff ^ ci_i;
        endcase
    end

    // Carry generation and result inversion.
    always_comb begin
        co_o    = (a_eff & b_eff) | (a_eff & ci_i) | (b_eff & ci_i);
        s_o     = raw ^ flip_res_i;
        raw_o   = raw;
        a_eff_o = a_eff;
        b_eff_o = b_eff;
    end

endmodule

// File: rtl/alu_chain.sv
// Module: WIDTH identical slices joined by a ripple carry.
// Assumes: WIDTH >= 2; carry vector index k is the carry into slice k.
module alu_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             keep_a_i,
    input  logic             keep_b_i,
    input  logic             flip_a_i,
    input  logic             flip_b_i,
    input  logic             flip_res_i,
    input  alu_pkg::alu_op_e op_i,
    input  logic             ci_i,
    output logic [WIDTH-1:0] a_eff_o,
    output logic [WIDTH-1:0] b_eff_o,
    output logic [WIDTH-1:0] raw_o,
    output logic [WIDTH-1:0] s_o,
    output logic [WIDTH:0]   carry_o
);
    logic [WIDTH:0] carry;

    // Chain entry: external carry feeds slice 0.
    always_comb carry[0] = ci_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_slice
        alu_slice u_slice (
            .a_i        (a_i[k]),
            .b_i        (b_i[k]),
            .keep_a_i   (keep_a_i),
            .keep_b_i   (keep_b_i),
            .flip_a_i   (flip_a_i),
            .flip_b_i   (flip_b_i),
            .flip_res_i (flip_res_i),
            .op_i       (op_i),
            .ci_i       (carry[k]),
            .a_eff_o    (a_eff_o[k]),
            .b_eff_o    (b_eff_o[k]),
            .raw_o      (raw_o[k]),
            .s_o        (s_o[k]),
            .co_o       (carry[k+1])
        );
    end

    // Expose the whole carry vector for flag extraction.
    always_comb carry_o = carry;

endmodule

// File: rtl/alu_flags.sv
// Module: derives six status flags from the chain outputs.
// Assumes: zero/negative/parity see the final (possibly inverted) result;
// carry/adjust/overflow see the uninverted ADD chain and are 0 for logic ops.
module alu_flags #(
    parameter int WIDTH   = 8,
    parameter int ADJ_POS = 4
) (
    input  alu_pkg::alu_op_e           op_i,
    input  logic [WIDTH-1:0]           res_i,
    input  logic [WIDTH-1:0]           raw_i,
    input  logic [WIDTH-1:0]           a_eff_i,
    input  logic [WIDTH-1:0]           b_eff_i,
    input  logic [WIDTH:0]             carry_i,
    output logic [alu_pkg::FLAG_W-1:0] flags_o
);
    import alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic is_add;
    logic same_sign;

    // Arithmetic qualifier and operand sign agreement.
    always_comb begin
        is_add    = (op_i == OP_ADD);
        same_sign = ~(a_eff_i[MSB] ^ b_eff_i[MSB]);
    end

    // Flag assembly in the fixed bit order of the package.
    always_comb begin
        flags_o        = '0;
        flags_o[FLG_C] = is_add & carry_i[WIDTH];
        flags_o[FLG_P] = ~(^res_i);
        flags_o[FLG_A] = is_add & carry_i[ADJ_POS];
        flags_o[FLG_Z] = (res_i == '0);
        flags_o[FLG_N] = res_i[MSB];
        flags_o[FLG_O] = is_add & same_sign & (raw_i[MSB] ^ a_eff_i[MSB]);
    end

endmodule

// File: rtl/alu_bitslice.sv
// Module: top of the bit-slice ALU. Combinational result, carry and flags,
// plus a registered copy of the flags.
// Assumes: synchronous active-low reset acts only on the flag register.
module alu_bitslice #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             keep_a,
    input  logic             keep_b,
    input  logic             flip_a,
    input  logic             flip_b,
    input  logic [1:0]       op_sel,
    input  logic             flip_res,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic [5:0]       flags,
    output logic [5:0]       flags_q
);
    import alu_pkg::*;

    localparam int ADJ_POS = WIDTH / 2;

    alu_op_e          op;
    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] raw;
    logic [WIDTH-1:0] res;
    logic [WIDTH:0]   carry;
    logic [FLAG_W-1:0] flg;

    // Select decode from the plain port into the enum type.
    always_comb op = alu_op_e'(op_sel);

    alu_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i        (opa),
        .b_i        (opb),
        .keep_a_i   (keep_a),
        .keep_b_i   (keep_b),
        .flip_a_i   (flip_a),
        .flip_b_i   (flip_b),
        .flip_res_i (flip_res),
        .op_i       (op),
        .ci_i       (carry_in),
        .a_eff_o    (a_eff),
        .b_eff_o    (b_eff),
        .raw_o      (raw),
        .s_o        (res),
        .carry_o    (carry)
    );

    alu_flags #(.WIDTH(WIDTH), .ADJ_POS(ADJ_POS)) u_flags (
        .op_i    (op),
        .res_i   (res),
        .raw_i   (raw),
        .a_eff_i (a_eff),
        .b_eff_i (b_eff),
        .carry_i (carry),
        .flags_o (flg)
    );

    // Output drive of the combinational results.
    always_comb begin
        result    = res;
        carry_out = carry[WIDTH];
        flags     = flg;
    end

    // Flag register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flg;
    end

endmodule

// File: rtl/alu_bitslice_chk.sv
// Module: checker for alu_bitslice, bound to every instance of the top.
// Assumes: inputs are stable around the rising clock edge.
module alu_bitslice_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             keep_a,
    input logic             keep_b,
    input logic             flip_a,
    input logic             flip_b,
    input logic [1:0]       op_sel,
    input logic             flip_res,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic [5:0]       flags,
    input logic [5:0]       flags_q
);
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 6'd0));

    // R11
    flag_reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (flags_q == $past(flags)));

    // R1
    gated_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11 && !keep_a && !keep_b && !flip_a && !flip_b && !flip_res)
        |-> (result == {{(WIDTH-1){1'b0}}, carry_in} && !carry_out));

    // R4
    subtract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b11 && keep_a && keep_b && !flip_a && flip_b && carry_in && !flip_res)
        |-> (result == WIDTH'(opa - opb) && carry_out == (opa >= opb)));

    // R5
    logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 2'b11) |-> !flags[0]);

    // R7
    logic_adjust_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 2'b11) |-> !flags[2]);

    // R10
    logic_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 2'b11) |-> !flags[5]);

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] == (result == '0));

    // R9
    negative_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[4] == result[WIDTH-1]);

endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa       (opa),
    .opb       (opb),
    .keep_a    (keep_a),
    .keep_b    (keep_b),
    .flip_a    (flip_a),
    .flip_b    (flip_b),
    .op_sel    (op_sel),
    .flip_res  (flip_res),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .flags     (flags),
    .flags_q   (flags_q)
);

// File: tb/sim_alu_bitslice.sv
// Bench: full operand sweep for ADD, control sweep on boundary operands,
// directed corner cases and flag register checks, against an arithmetic model.
module sim_alu_bitslice;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       keep_a = 1'b1;
    logic       keep_b = 1'b1;
    logic       flip_a = 1'b0;
    logic       flip_b = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic       flip_res = 1'b0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       carry_out;
    logic [5:0] flags;
    logic [5:0] flags_q;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [5:0] prev_f = '0;
    logic       prev_ok = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu_bitslice u0 (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .keep_a(keep_a), .keep_b(keep_b), .flip_a(flip_a), .flip_b(flip_b),
        .op_sel(op_sel), .flip_res(flip_res), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .flags(flags), .flags_q(flags_q)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s a=%h b=%h ctl=%b%b%b%b op=%b fr=%b ci=%b actual=%h expected=%h",
                     tag, opa, opb, keep_a, keep_b, flip_a, flip_b, op_sel, flip_res,
                     carry_in, act, exp);
        end
    endtask

    // Arithmetic model built from the requirements.
    task automatic model(input logic [7:0] a, input logic [7:0] b, input logic ka,
                         input logic kb, input logic fa, input logic fb,
                         input logic [1:0] op, input logic fr, input logic ci,
                         output logic [7:0] r, output logic co, output logic [5:0] f);
        logic [7:0] ae, be, raw;
        logic [8:0] sum;
        logic [4:0] lo;
        ae  = (ka ? a : 8'h00) ^ (fa ? 8'hFF : 8'h00);
        be  = (kb ? b : 8'h00) ^ (fb ? 8'hFF : 8'h00);
        sum = {1'b0, ae} + {1'b0, be} + {8'h00, ci};
        lo  = {1'b0, ae[3:0]} + {1'b0, be[3:0]} + {4'h0, ci};
        case (op)
            2'b00:   raw = ae & be;
            2'b01:   raw = ae | be;
            2'b10:   raw = ae ^ be;
            default: raw = sum[7:0];
        endcase
        r    = fr ? ~raw : raw;
        co   = sum[8];
        f[0] = (op == 2'b11) && sum[8];
        f[1] = ($countones(r) % 2) == 0;
        f[2] = (op == 2'b11) && lo[4];
        f[3] = (r == 8'h00);
        f[4] = r[7];
        f[5] = (op == 2'b11) && (ae[7] == be[7]) && (sum[7] != ae[7]);
    endtask

    // Apply one vector at the falling edge and compare every output.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic ka,
                         input logic kb, input logic fa, input logic fb,
                         input logic [1:0] op, input logic fr, input logic ci);
        logic [7:0] r;
        logic       co;
        logic [5:0] f;
        @(negedge clk);
        if (prev_ok) check("R11 flags_q", {2'b00, flags_q}, {2'b00, prev_f});
        opa = a; opb = b; keep_a = ka; keep_b = kb; flip_a = fa; flip_b = fb;
        op_sel = op; flip_res = fr; carry_in = ci;
        #1;
        model(a, b, ka, kb, fa, fb, op, fr, ci, r, co, f);
        check((op == 2'b11) ? "R4 result" : "R3 result", result, r);
        check("R4 carry_out", {7'd0, carry_out}, {7'd0, co});
        check("R5 carry flag", {7'd0, flags[0]}, {7'd0, f[0]});
        check("R6 parity flag", {7'd0, flags[1]}, {7'd0, f[1]});
        check("R7 adjust flag", {7'd0, flags[2]}, {7'd0, f[2]});
        check("R8 zero flag", {7'd0, flags[3]}, {7'd0, f[3]});
        check("R9 negative flag", {7'd0, flags[4]}, {7'd0, f[4]});
        check("R10 overflow flag", {7'd0, flags[5]}, {7'd0, f[5]});
        prev_f  = f;
        prev_ok = 1'b1;
    endtask

    initial begin
        logic [7:0] pick [8];
        pick = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF};

        // R11: reset state of the flag register.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", {2'b00, flags_q}, 8'h00);
        rst_n = 1'b1;

        // R1: gated operands read as zero.
        apply(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);
        check("R1 gate A", result, 8'h00);
        apply(8'h00, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);
        check("R1 gate B", result, 8'h00);
        // R2: inversion after gating gives all ones.
        apply(8'h3C, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0);
        check("R2 invert after gate", result, 8'hFF);
        // R4: subtraction with borrow and without.
        apply(8'h05, 8'h09, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
        check("R4 sub borrow", {carry_out, result[6:0]}, {1'b0, 7'h7C});
        apply(8'h09, 8'h09, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1);
        check("R4 sub equal zero", {carry_out, flags[3], 6'd0}, 8'hC0);
        // R10, R7, R5: boundary sums.
        apply(8'h7F, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        check("R10 positive overflow", {7'd0, flags[5]}, 8'h01);
        apply(8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        check("R10 negative overflow", {7'd0, flags[5]}, 8'h01);
        apply(8'h0F, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        check("R7 nibble carry", {7'd0, flags[2]}, 8'h01);
        apply(8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        check("R5 wrap carry", {2'b00, flags}, 8'h0F);
        // R3: inverted ADD result, flags follow the inverted value.
        apply(8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0);
        check("R3 inverted sum", result, 8'hFF);

        // R4: full operand sweep for ADD.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b), 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0,
                      1'(a ^ (b >> 1)));
            end
        end

        // R1 R2 R3 R6: every control combination on boundary operands.
        for (int c = 0; c < 256; c++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    apply(pick[i], pick[j], c[0], c[1], c[2], c[3], 2'(c >> 4),
                          c[6], c[7]);
                end
            end
        end

        // R11: reset during operation clears nonzero flags.
        apply(8'hFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset", {2'b00, flags_q}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule